// File: doc/BRIEF.md
# Aggregate Peak-Rate Cell Gate

This block limits the peak cell rate of a whole link, handled as one connection, by cutting time windows into the byte stream instead of comparing arrival timestamps. Bytes come in one per valid beat, with a flag on the first byte of each cell from an upstream delineator. When a cell starts while the gate is ready, exactly one cell of valid beats passes through unchanged, one clock later. The gate then closes for a programmable interval, then for a short fixed recovery time, and only after that reopens. No byte is ever stored or delayed beyond the single output register.

Cells that start while the gate is closed are dropped and counted. A cell whose tail is still arriving when the gate reopens stays dropped, because only a start flag can open a window. The closed interval is set by a small unsigned field. Each bit of that field switches in one binary-weighted delay stage, so the run-time setting maps to a peak rate agreed per contract.

Top module: `pcr_gate_policer`

## Requirements
- R1: With the gate ready, a valid beat with `in_sop_i` high opens a window, and the next CELL_BYTES valid beats, counted on valid beats only and including the opening one, appear on the output one clock after they are sampled, with data unchanged and `out_sop_o` high only with the opening beat.
- R2: After the last beat of a window, the gate stays closed for `idle_steps_i`×STEP_CYCLES clock cycles and then for RECOVER_CYCLES more. A start flag in the first cycle after that opens a new window.
- R3: A cell whose start flag arrives while the gate is closed or recovering is not forwarded at all, and it neither restarts nor lengthens the closed interval.
- R4: While the gate is ready, valid beats without a start flag, such as the tail of a dropped cell, are dropped and do not open a window.
- R5: With `idle_steps_i` zero, the gate is ready again in the cycle right after the last beat, with no recovery time, so back-to-back cells all pass.
- R6: `idle_steps_i` is sampled on the opening beat of a window. Changing it during the window does not change the closed interval that follows that window.
- R7: Bit i of `idle_steps_i` adds a delay stage of 2^i×STEP_CYCLES cycles. The longest interval is (2^STAGES−1)×STEP_CYCLES cycles.
- R8: `pass_count_o` goes up by one for each opened window, in the cycle its opening beat is output. `discard_count_o` goes up by one for each start flag sampled while the gate is closed or recovering. Dropped tails and stray beats change neither counter.
- R9: While `rst_ni` is low, the gate is ready, `out_valid_o` and `out_sop_o` are low, and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_sop_i | input | 1 | Input byte is the first of a cell |
| in_data_i | input | DATA_W | Input byte |
| idle_steps_i | input | STAGES | Closed-interval setting in step units |
| out_valid_o | output | 1 | Forwarded byte valid |
| out_sop_o | output | 1 | Forwarded byte opens a window |
| out_data_o | output | DATA_W | Forwarded byte |
| pass_count_o | output | CNT_W | Cells passed |
| discard_count_o | output | CNT_W | Cells discarded |

## Verification
The hardest case to reach is a dropped cell that straddles the reopening: the closed interval and recovery must end while that cell's tail is still arriving. The stimulus gets there by sending cells back to back, each right after the last, across every interval setting, with and without gaps inside cells. For short settings, this makes the gate reopen in the middle of a dropped cell. A reference model in the bench tracks the cycle at which the gate reopens from the interval arithmetic alone. Every output beat and counter is compared against it in every cycle.

// File: rtl/pcr_gate_pkg.sv
package pcr_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PASS    = 2'd1,
    ST_BLOCK   = 2'd2,
    ST_RECOVER = 2'd3
  } gate_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcr_weighted_delay.sv
module pcr_weighted_delay #(
  parameter int unsigned STAGES      = 5,
  parameter int unsigned STEP_CYCLES = 8,
  parameter int unsigned TIMER_W     = 8
) (
  input  logic [STAGES-1:0]  steps_i,
  output logic [TIMER_W-1:0] delay_o
);

  logic [TIMER_W-1:0] partial [STAGES+1];

  assign partial[0] = '0;

  // one switched stage per bit, weight doubling per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam int unsigned WEIGHT = (32'd1 << g) * STEP_CYCLES;
    localparam logic [TIMER_W-1:0] WEIGHT_W = TIMER_W'(WEIGHT);
    assign partial[g+1] = partial[g] + (steps_i[g] ? WEIGHT_W : '0);
  end

  assign delay_o = partial[STAGES];

endmodule

// File: rtl/pcr_window_fsm.sv
module pcr_window_fsm
  import pcr_gate_pkg::*;
#(
  parameter int unsigned CELL_BYTES     = 53,
  parameter int unsigned RECOVER_CYCLES = 2,
  parameter int unsigned TIMER_W        = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               beat_valid_i,
  input  logic               beat_sop_i,
  input  logic [TIMER_W-1:0] delay_i,
  output logic               accept_o,
  output logic               open_o,
  output logic               discard_o
);

  localparam int unsigned BEAT_W = $clog2(CELL_BYTES + 1);
  localparam logic [BEAT_W-1:0]  LAST_BEAT = BEAT_W'(CELL_BYTES - 1);
  localparam logic [TIMER_W-1:0] REC_W     = TIMER_W'(RECOVER_CYCLES);
  localparam logic [TIMER_W-1:0] ONE_T     = TIMER_W'(1);

  gate_state_e        state_q, state_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic [TIMER_W-1:0] timer_q, timer_d;

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    timer_d   = timer_q;
    accept_o  = 1'b0;
    open_o    = 1'b0;
    discard_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // only a real start flag opens a window
        if (beat_valid_i && beat_sop_i) begin
          accept_o = 1'b1;
          open_o   = 1'b1;
          if (CELL_BYTES == 1) begin
            timer_d = delay_i;
            state_d = (delay_i == '0) ? ST_IDLE : ST_BLOCK;
          end else begin
            beat_d  = BEAT_W'(1);
            state_d = ST_PASS;
          end
        end
      end
      ST_PASS: begin
        if (beat_valid_i) begin
          accept_o = 1'b1;
          if (beat_q == LAST_BEAT) begin
            beat_d  = '0;
            timer_d = delay_i;
            state_d = (delay_i == '0) ? ST_IDLE : ST_BLOCK;
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
      end
      ST_BLOCK, ST_RECOVER: begin
        discard_o = beat_valid_i && beat_sop_i;
        if (timer_q <= ONE_T) begin
          if (state_q == ST_BLOCK && RECOVER_CYCLES != 0) begin
            timer_d = REC_W;
            state_d = ST_RECOVER;
          end else begin
            timer_d = '0;
            state_d = ST_IDLE;
          end
        end else begin
          timer_d = timer_q - ONE_T;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      timer_q <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      timer_q <= timer_d;
    end
  end

endmodule

// File: rtl/pcr_cell_counters.sv
module pcr_cell_counters #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pass_inc_i,
  input  logic             drop_inc_i,
  output logic [CNT_W-1:0] pass_count_o,
  output logic [CNT_W-1:0] drop_count_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_count_o <= '0;
      drop_count_o <= '0;
    end else begin
      if (pass_inc_i) pass_count_o <= pass_count_o + CNT_W'(1);
      if (drop_inc_i) drop_count_o <= drop_count_o + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pcr_gate_policer.sv
module pcr_gate_policer
  import pcr_gate_pkg::*;
#(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned CELL_BYTES     = 53,
  parameter int unsigned STAGES         = 5,
  parameter int unsigned STEP_CYCLES    = 8,
  parameter int unsigned RECOVER_CYCLES = 2,
  parameter int unsigned CNT_W          = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [STAGES-1:0] idle_steps_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [CNT_W-1:0]  pass_count_o,
  output logic [CNT_W-1:0]  discard_count_o
);

  localparam int unsigned MAX_DELAY = ((32'd1 << STAGES) - 1) * STEP_CYCLES;
  localparam int unsigned TIMER_MAX = max_u(MAX_DELAY, RECOVER_CYCLES);
  localparam int unsigned TIMER_W   = $clog2(TIMER_MAX + 2);

  logic [STAGES-1:0]  setting_q;
  logic [TIMER_W-1:0] delay_cycles;
  logic               accept, open_win, discard;

  pcr_weighted_delay #(
    .STAGES     (STAGES),
    .STEP_CYCLES(STEP_CYCLES),
    .TIMER_W    (TIMER_W)
  ) delay_i (
    .steps_i(setting_q),
    .delay_o(delay_cycles)
  );

  pcr_window_fsm #(
    .CELL_BYTES    (CELL_BYTES),
    .RECOVER_CYCLES(RECOVER_CYCLES),
    .TIMER_W       (TIMER_W)
  ) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_valid_i(in_valid_i),
    .beat_sop_i  (in_sop_i),
    .delay_i     (delay_cycles),
    .accept_o    (accept),
    .open_o      (open_win),
    .discard_o   (discard)
  );

  pcr_cell_counters #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pass_inc_i  (open_win),
    .drop_inc_i  (discard),
    .pass_count_o(pass_count_o),
    .drop_count_o(discard_count_o)
  );

  // setting is held for the whole window it was sampled with
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setting_q <= '0;
    end else if (open_win) begin
      setting_q <= idle_steps_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= accept;
      out_sop_o   <= open_win;
      if (accept) out_data_o <= in_data_i;
    end
  end

endmodule

// File: rtl/pcr_gate_policer_chk.sv
module pcr_gate_policer_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned CNT_W      = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_sop_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic              out_sop_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [CNT_W-1:0]  pass_count_o,
  input logic [CNT_W-1:0]  discard_count_o
);

  int unsigned fwd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_cnt <= 0;
    else if (out_valid_o) fwd_cnt <= out_sop_o ? 1 : fwd_cnt + 1;
  end

  AST_FWD_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i)); // R1

  AST_FWD_DATA_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o == $past(in_data_i)); // R1

  AST_WINDOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_sop_o) |-> (fwd_cnt >= 1 && fwd_cnt < CELL_BYTES)); // R1

  AST_OPEN_NEEDS_SOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> (out_valid_o && $past(in_sop_i))); // R4

  AST_DROP_NOT_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_count_o != $past(discard_count_o)) |-> ($past(in_valid_i && in_sop_i) && !out_valid_o)); // R3

  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_count_o != $past(discard_count_o)) |-> discard_count_o == $past(discard_count_o) + 1'b1); // R8

  AST_PASS_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_count_o != $past(pass_count_o)) |-> (out_sop_o && pass_count_o == $past(pass_count_o) + 1'b1)); // R8

endmodule

bind pcr_gate_policer pcr_gate_policer_chk #(
  .DATA_W    (DATA_W),
  .CELL_BYTES(CELL_BYTES),
  .CNT_W     (CNT_W)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_valid_i     (in_valid_i),
  .in_sop_i       (in_sop_i),
  .in_data_i      (in_data_i),
  .out_valid_o    (out_valid_o),
  .out_sop_o      (out_sop_o),
  .out_data_o     (out_data_o),
  .pass_count_o   (pass_count_o),
  .discard_count_o(discard_count_o)
);

// File: tb/pcr_gate_policer_tb_top.sv
module pcr_gate_policer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int CELL       = 4;
  localparam int STAGES     = 3;
  localparam int STEP       = 2;
  localparam int REC        = 1;
  localparam int CNT_W      = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic              in_sop_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic [STAGES-1:0] idle_steps_i = '0;
  logic              out_valid_o, out_sop_o;
  logic [DATA_W-1:0] out_data_o;
  logic [CNT_W-1:0]  pass_count_o, discard_count_o;

  pcr_gate_policer #(
    .DATA_W(DATA_W), .CELL_BYTES(CELL), .STAGES(STAGES),
    .STEP_CYCLES(STEP), .RECOVER_CYCLES(REC), .CNT_W(CNT_W)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_sop_i(in_sop_i),
    .in_data_i(in_data_i), .idle_steps_i(idle_steps_i), .out_valid_o(out_valid_o),
    .out_sop_o(out_sop_o), .out_data_o(out_data_o), .pass_count_o(pass_count_o),
    .discard_count_o(discard_count_o)
  );

  initial forever #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R9";

  // reference model state
  int edge_no = 0;
  int ready_at = 0;
  int pass_left = 0;
  int latched = 0;
  int exp_pass = 0;
  int exp_disc = 0;
  bit exp_valid = 0;
  bit exp_sop = 0;
  logic [DATA_W-1:0] exp_data = '0;
  logic [DATA_W-1:0] byte_ctr = 8'h10;

  task automatic check(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    check("out_valid", out_valid_o, exp_valid);
    check("out_sop", out_sop_o, exp_sop);
    if (exp_valid) check("out_data", out_data_o, exp_data);
    check("pass_count", pass_count_o, exp_pass);
    check("discard_count", discard_count_o, exp_disc);
  endtask

  // one clock: check previous result, drive, predict, advance
  task automatic beat(input bit v, input bit s);
    int d;
    check_outputs();
    in_valid_i = v;
    in_sop_i   = s;
    in_data_i  = byte_ctr;
    exp_valid  = 0;
    exp_sop    = 0;
    if (pass_left > 0) begin
      if (v) begin
        exp_valid = 1;
        exp_data  = byte_ctr;
        pass_left--;
        if (pass_left == 0) begin
          d = latched * STEP;
          ready_at = edge_no + 1 + d + ((d > 0) ? REC : 0);
        end
      end
    end else if (edge_no >= ready_at) begin
      if (v && s) begin
        exp_valid = 1;
        exp_sop   = 1;
        exp_data  = byte_ctr;
        exp_pass++;
        latched   = int'(idle_steps_i);
        pass_left = CELL - 1;
        if (pass_left == 0) begin
          d = latched * STEP;
          ready_at = edge_no + 1 + d + ((d > 0) ? REC : 0);
        end
      end
    end else if (v && s) begin
      exp_disc++;
    end
    if (v) byte_ctr = byte_ctr + 8'd7;
    edge_no++;
    @(negedge clk_i);
  endtask

  task automatic send_cell(input bit bubble);
    for (int i = 0; i < CELL; i++) begin
      if (bubble && i == 2) beat(1'b0, 1'b0);
      beat(1'b1, i == 0);
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) beat(1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R9";
    check("reset out_valid", out_valid_o, 0);
    check("reset out_sop", out_sop_o, 0);
    check("reset pass_count", pass_count_o, 0);
    check("reset discard_count", discard_count_o, 0);
    rst_ni = 1'b1;

    // R9: ready right after reset
    cur_req = "R9";
    idle_steps_i = 3'd2;
    send_cell(0);
    gap(12);

    // R1: continuous stream, fixed setting
    cur_req = "R1";
    idle_steps_i = 3'd3;
    for (int c = 0; c < 10; c++) send_cell(c % 2);
    gap(20);

    // R5: zero setting lets back-to-back cells through
    cur_req = "R5";
    idle_steps_i = 3'd0;
    for (int c = 0; c < 6; c++) send_cell(0);
    gap(4);

    // R4: stray beats with the gate ready, then tails across reopening
    cur_req = "R4";
    for (int i = 0; i < 5; i++) beat(1'b1, 1'b0);
    idle_steps_i = 3'd1;
    for (int c = 0; c < 8; c++) send_cell(0);
    gap(12);

    // R6: setting changed mid-window
    cur_req = "R6";
    idle_steps_i = 3'd7;
    beat(1'b1, 1'b1);
    idle_steps_i = 3'd0;
    for (int i = 1; i < CELL; i++) beat(1'b1, 1'b0);
    for (int c = 0; c < 5; c++) send_cell(0);
    gap(20);

    // R3: dense start flags while closed
    cur_req = "R3";
    idle_steps_i = 3'd5;
    send_cell(0);
    for (int i = 0; i < 8; i++) beat(1'b1, 1'b1);
    gap(24);

    // R2 / R7: sweep every setting, gap and bubble pattern
    for (int s = 0; s < (1 << STAGES); s++) begin
      for (int g = 0; g < 4; g++) begin
        for (int b = 0; b < 2; b++) begin
          cur_req = (s == 0) ? "R2" : "R7";
          idle_steps_i = STAGES'(s);
          for (int c = 0; c < 6; c++) begin
            send_cell(b[0] && c[0]);
            gap(g);
          end
          gap(20);
        end
      end
    end

    // R8: final counters after settling
    cur_req = "R8";
    gap(4);
    check_outputs();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule